// File: doc/BRIEF.md
# I2C Status Flags and Clock-Stretch Controller

This block holds the status and interrupt flags of an I2C controller. A separate byte engine sends it single-cycle event pulses and two mode levels. The pulses report a finished byte, a STOP, a match on the own address, a match on the general call address, an acknowledged address, a lost arbitration and a sampled ACK. The levels say whether the engine is transmitting and whether it is master. The block also watches the synchronized SDA and SCL lines so that it can tell whether the bus is in use.

The block turns these inputs into an 8-bit read-only status byte, an interrupt request and a request to hold SCL low. The hold request is the clock stretch that makes the bus wait for software. A CPU write strobe acknowledges the interrupt. It clears the sticky flags and lets SCL go. No data comes with the write, because any written value has the same effect.

Top module: `i2c_stat_hold`

## Requirements
- R1: After reset, status is 0x00, and irq and scl_hold are both 0.
- R2: Bit 7 is sticky. In master mode (lv_is_master=1) it sets on ev_addr_ack. In slave mode (lv_is_master=0) it sets on ev_gcall_match. ev_gcall_match has no effect in master mode, and ev_addr_ack has no effect in slave mode.
- R3: Each of these flags is sticky and sets one cycle after its pulse: bit 6 on ev_byte_done, bit 5 on ev_stop, bit 4 on ev_own_match, bit 3 on ev_arb_lost and bit 0 on ev_ack_sampled.
- R4: Bit 2 (bus busy) sets when SDA falls while SCL is high in both samples. It clears when SDA rises while SCL is high in both samples. An SDA change while SCL is low leaves it unchanged, and a CPU write does not clear it.
- R5: Bit 1 follows lv_is_tx live, with no latching.
- R6: irq is 1 exactly when at least one of status bits 7, 6, 5, 4, 3 or 0 is set.
- R7: An event that sets bit 7, 6, 4, 3 or 0 raises scl_hold on the same edge. An ev_stop on its own raises irq but does not raise scl_hold.
- R8: A cpu_wr pulse clears bits 7, 6, 5, 4, 3 and 0 and drops scl_hold. It leaves bit 2 unchanged.
- R9: When an event pulse arrives in the same cycle as cpu_wr, the event's flag ends up set. If the event is a hold source, scl_hold ends up 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_byte_done | input | 1 | Pulse: a byte has been fully transferred |
| ev_stop | input | 1 | Pulse: STOP condition detected |
| ev_own_match | input | 1 | Pulse: addressed as slave by another master |
| ev_gcall_match | input | 1 | Pulse: general call address received |
| ev_addr_ack | input | 1 | Pulse: the slave acknowledged our address |
| ev_arb_lost | input | 1 | Pulse: arbitration lost |
| ev_ack_sampled | input | 1 | Pulse: ACK present in the ninth clock |
| lv_is_tx | input | 1 | Level: 1 when transmitting, 0 when receiving |
| lv_is_master | input | 1 | Level: 1 in master mode, 0 in slave mode |
| sda_sync | input | 1 | Synchronized SDA line |
| scl_sync | input | 1 | Synchronized SCL line |
| cpu_wr | input | 1 | CPU write strobe to the status byte |
| status | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| scl_hold | output | 1 | Request to hold SCL low |

## Verification
The bench checks bit 7 under both mode levels, including the cases that must not set it, such as a general-call match in master mode. A design with the wrong mode select would set the flag in those cases, and the bench would see it. A lone STOP must raise irq without stretching the clock; a design that treats STOP as a hold source would stall the bus. The bench drives an event and a CPU write in the same cycle and expects the event's flag and hold to survive, because a clear-first design would lose the event. It also wiggles SDA while SCL is low and issues writes while the bus is busy, so a busy tracker that decodes false START/STOP conditions or is cleared by software is caught.

// File: rtl/i2c_stat_pkg.sv
package i2c_stat_pkg;
  // status byte bit positions (software decodes these)
  localparam int unsigned ST_BIT7  = 7;
  localparam int unsigned ST_TEND  = 6;
  localparam int unsigned ST_STOP  = 5;
  localparam int unsigned ST_SSEL  = 4;
  localparam int unsigned ST_LOST  = 3;
  localparam int unsigned ST_BUSY  = 2;
  localparam int unsigned ST_TX    = 1;
  localparam int unsigned ST_ACK   = 0;

  // sticky source vector indices
  localparam int unsigned NSRC     = 6;
  localparam int unsigned SRC_ACK  = 0;
  localparam int unsigned SRC_LOST = 1;
  localparam int unsigned SRC_SSEL = 2;
  localparam int unsigned SRC_STOP = 3;
  localparam int unsigned SRC_TEND = 4;
  localparam int unsigned SRC_BIT7 = 5;

  // every source except STOP stretches the clock
  localparam logic [NSRC-1:0] HOLD_MASK = ~(NSRC'(1) << SRC_STOP);
endpackage

// File: rtl/i2c_rst_sync.sv
module i2c_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int unsigned LAST = STAGES - 1;

  logic [STAGES-1:0] chain_q;

  generate
    genvar gi;
    for (gi = 0; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[gi] <= 1'b0;
        else if (gi == 0) chain_q[gi] <= 1'b1;
        else chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
      end
    end
  endgenerate

  assign rst_n_sync = chain_q[LAST];
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor (
  input  logic clk,
  input  logic rst_n,
  input  logic sda_sync,
  input  logic scl_sync,
  output logic busy
);
  logic sda_q, scl_q, busy_q;
  logic busy_d, start_seen, stop_seen, busy_en;

  always_comb begin
    start_seen = scl_sync && scl_q && sda_q && !sda_sync;
    stop_seen  = scl_sync && scl_q && !sda_q && sda_sync;
    busy_en    = start_seen || stop_seen;
    busy_d     = start_seen;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sda_q <= 1'b1;
      scl_q <= 1'b1;
    end else begin
      sda_q <= sda_sync;
      scl_q <= scl_sync;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else if (busy_en) busy_q <= busy_d;
  end

  assign busy = busy_q;

  AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_sync && $past(scl_sync) && $fell(sda_sync)) |=> busy_q); // R4
  AST_IDLE_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_sync && $past(scl_sync) && $rose(sda_sync)) |=> !busy_q); // R4
  AST_BUSY_STILL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_sync && !scl_q) |=> $stable(busy_q)); // R4
endmodule

// File: rtl/i2c_stat_flags.sv
module i2c_stat_flags
  import i2c_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic            cpu_wr,
  output logic [NSRC-1:0] flags,
  output logic            hold
);
  logic [NSRC-1:0] flags_q, flags_d;
  logic            hold_q, hold_d, hold_set, hold_en;

  generate
    genvar gi;
    for (gi = 0; gi < NSRC; gi++) begin : g_flag
      logic en;
      always_comb begin
        en          = set_vec[gi] || cpu_wr;
        flags_d[gi] = set_vec[gi];  // event wins over the clear
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q[gi] <= 1'b0;
        else if (en) flags_q[gi] <= flags_d[gi];
      end
    end
  endgenerate

  always_comb begin
    hold_set = |(set_vec & HOLD_MASK);
    hold_en  = hold_set || cpu_wr;
    hold_d   = hold_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else if (hold_en) hold_q <= hold_d;
  end

  assign flags = flags_q;
  assign hold  = hold_q;

  AST_HOLD_ON_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & HOLD_MASK)) |=> hold_q); // R7
  AST_STOP_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!hold_q && set_vec == (NSRC'(1) << SRC_STOP)) |=> (!hold_q && flags_q[SRC_STOP])); // R7
  AST_WRITE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !(|(set_vec & HOLD_MASK))) |=> !hold_q); // R8
  AST_EVENT_BEATS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && |set_vec) |=> ((flags_q & $past(set_vec)) == $past(set_vec))); // R9
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && set_vec == '0) |=> (flags_q == '0)); // R8
endmodule

// File: rtl/i2c_stat_hold.sv
module i2c_stat_hold
  import i2c_stat_pkg::*;
#(
  parameter int unsigned RST_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_byte_done,
  input  logic       ev_stop,
  input  logic       ev_own_match,
  input  logic       ev_gcall_match,
  input  logic       ev_addr_ack,
  input  logic       ev_arb_lost,
  input  logic       ev_ack_sampled,
  input  logic       lv_is_tx,
  input  logic       lv_is_master,
  input  logic       sda_sync,
  input  logic       scl_sync,
  input  logic       cpu_wr,
  output logic [7:0] status,
  output logic       irq,
  output logic       scl_hold
);
  logic            rst_n_i;
  logic [NSRC-1:0] set_vec, flags;
  logic            busy;

  i2c_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_i)
  );

  always_comb begin
    set_vec           = '0;
    set_vec[SRC_ACK]  = ev_ack_sampled;
    set_vec[SRC_LOST] = ev_arb_lost;
    set_vec[SRC_SSEL] = ev_own_match;
    set_vec[SRC_STOP] = ev_stop;
    set_vec[SRC_TEND] = ev_byte_done;
    set_vec[SRC_BIT7] = lv_is_master ? ev_addr_ack : ev_gcall_match;
  end

  i2c_stat_flags u_flags (
    .clk(clk), .rst_n(rst_n_i), .set_vec(set_vec), .cpu_wr(cpu_wr),
    .flags(flags), .hold(scl_hold)
  );

  i2c_bus_monitor u_bus (
    .clk(clk), .rst_n(rst_n_i), .sda_sync(sda_sync), .scl_sync(scl_sync),
    .busy(busy)
  );

  always_comb begin
    status          = '0;
    status[ST_BIT7] = flags[SRC_BIT7];
    status[ST_TEND] = flags[SRC_TEND];
    status[ST_STOP] = flags[SRC_STOP];
    status[ST_SSEL] = flags[SRC_SSEL];
    status[ST_LOST] = flags[SRC_LOST];
    status[ST_BUSY] = busy;
    status[ST_TX]   = lv_is_tx;
    status[ST_ACK]  = flags[SRC_ACK];
    irq             = |flags;
  end

  AST_BUSY_SURVIVES_WRITE: assert property (@(posedge clk) disable iff (!rst_n_i)
    (cpu_wr && !(scl_sync && $past(scl_sync) && (sda_sync != $past(sda_sync))))
      |=> (status[ST_BUSY] == $past(status[ST_BUSY]))); // R8
  AST_MODE_GATES_BIT7: assert property (@(posedge clk) disable iff (!rst_n_i)
    (!cpu_wr && !status[ST_BIT7] && lv_is_master && !ev_addr_ack) |=> !status[ST_BIT7]); // R2
  AST_HOLD_ONLY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n_i)
    scl_hold |-> irq); // R6
endmodule

// File: tb/sim_i2c_stat_hold.sv
`timescale 1ns/1ps
module sim_i2c_stat_hold;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ev_byte_done = 0, ev_stop = 0, ev_own_match = 0, ev_gcall_match = 0;
  logic ev_addr_ack = 0, ev_arb_lost = 0, ev_ack_sampled = 0;
  logic lv_is_tx = 0, lv_is_master = 0, sda_sync = 1, scl_sync = 1, cpu_wr = 0;
  logic [7:0] status;
  logic irq, scl_hold;

  always #2.5 clk = ~clk;

  i2c_stat_hold u0 (.*);

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       irq;
    logic       hold;
  } exp_t;

  exp_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // reference model state
  logic [7:0] m_stk = 8'h00; // sticky bits in status positions
  logic m_busy = 0, m_hold = 0, m_sda = 1, m_scl = 1;

  task automatic tick(string tag);
    logic [7:0] setv;
    exp_t e;
    @(posedge clk);
    setv = 8'h00;
    setv[7] = lv_is_master ? ev_addr_ack : ev_gcall_match; // R2
    setv[6] = ev_byte_done; setv[5] = ev_stop; setv[4] = ev_own_match;
    setv[3] = ev_arb_lost;  setv[0] = ev_ack_sampled;     // R3
    m_stk  = setv | (m_stk & {8{~cpu_wr}});               // R8 R9
    m_hold = (|(setv & 8'hDF)) | (m_hold & ~cpu_wr);      // R7
    if (scl_sync && m_scl && m_sda && !sda_sync) m_busy = 1;       // R4
    else if (scl_sync && m_scl && !m_sda && sda_sync) m_busy = 0;
    m_sda = sda_sync; m_scl = scl_sync;
    e.tag = tag;
    e.st = m_stk | {5'b0, m_busy, lv_is_tx, 1'b0};
    e.irq = |m_stk;                                        // R6
    e.hold = m_hold;
    q.push_back(e);
    @(negedge clk);
    ev_byte_done = 0; ev_stop = 0; ev_own_match = 0; ev_gcall_match = 0;
    ev_addr_ack = 0; ev_arb_lost = 0; ev_ack_sampled = 0; cpu_wr = 0;
  endtask

  // monitor: compares after each edge the driver recorded
  always @(posedge clk) begin
    #1;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (status !== e.st || irq !== e.irq || scl_hold !== e.hold) begin
        n_fail++;
        $display("FAIL %s: status=%02h irq=%0b hold=%0b expected status=%02h irq=%0b hold=%0b",
                 e.tag, status, irq, scl_hold, e.st, e.irq, e.hold);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (3) @(negedge clk);
    tick("R1 reset state");
    ev_byte_done = 1;            tick("R3 R7 byte done sets bit6 and holds");
    tick("R3 bit6 sticky");
    cpu_wr = 1;                  tick("R8 write clears and releases");
    lv_is_master = 1; ev_addr_ack = 1; tick("R2 master address ack");
    cpu_wr = 1;                  tick("R8 clear bit7");
    ev_gcall_match = 1;          tick("R2 gcall ignored in master mode");
    lv_is_master = 0; ev_addr_ack = 1; tick("R2 addr ack ignored in slave mode");
    ev_gcall_match = 1;          tick("R2 slave general call");
    cpu_wr = 1;                  tick("R8 clear");
    ev_stop = 1;                 tick("R7 stop alone no hold");
    cpu_wr = 1;                  tick("R8 clear stop");
    ev_own_match = 1;            tick("R3 own match");
    ev_arb_lost = 1;             tick("R3 arbitration lost");
    ev_ack_sampled = 1;          tick("R3 R6 ack sampled accumulates");
    cpu_wr = 1;                  tick("R8 clear all");
    lv_is_tx = 1;                tick("R5 transmitter");
    lv_is_tx = 0;                tick("R5 receiver");
    sda_sync = 0;                tick("R4 START sets busy");
    cpu_wr = 1;                  tick("R4 R8 write keeps busy");
    scl_sync = 0;                tick("R4 scl low");
    sda_sync = 1;                tick("R4 sda rise with scl low ignored");
    sda_sync = 0;                tick("R4 sda fall with scl low ignored");
    scl_sync = 1;                tick("R4 scl high");
    sda_sync = 1;                tick("R4 STOP clears busy");
    ev_byte_done = 1;            tick("R3 set before race");
    cpu_wr = 1; ev_ack_sampled = 1; tick("R9 event beats write");
    cpu_wr = 1; ev_stop = 1;     tick("R9 stop with write: flag kept, hold released");
    cpu_wr = 1;                  tick("R8 final clear");
    repeat (2) @(posedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule